// File: doc/BRIEF.md
# Linkable Down-Counting Timer Group

A bank of `N` narrow down-counters, four of `WIDTH` = 8 bits by default, that share one free-running prescaler. Each unit picks its count pulse from one of these sources: every I/O clock cycle, one of two prescaled ticks (divide by 8 and by 32), a rising edge on its own external clock pin, or the underflow of the unit below it in the ring. A unit whose link bit is set is joined to the unit beneath it. The pair then behaves as one wider counter, so four units can form counters of 8, 16, 24 or 32 bits.

A unit counts down. When it holds zero and a count pulse arrives, it reloads from its reload register and underflows. Only the topmost unit of a linked chain reports that underflow to the outside. The report is a one-cycle interrupt pulse, an optional one-cycle A/D start pulse, and a change of state on a square-wave output. Software reaches the bank through a small flat register port. That port writes the reload and control registers, reads back the live count, and reads back the control bits.

Top module: `tmr_cascade_group`

## Requirements
- R1: After reset every control and reload register is zero. Every count reads 0, and `irq_o`, `tog_o` and `adc_trig_o` are all 0.
- R2: While a unit's effective run bit is 0, its count reads back its reload value, its `tog_o` bit is 0 and it raises no interrupt.
- R3: With the every-cycle source (src 0) and reload R, the first `irq_o` pulse follows R+1 clock edges after the edge that writes run=1. Further pulses come every R+1 cycles, and each pulse lasts one cycle.
- R4: With src 1 the pulse spacing is (R+1)*8 cycles. With src 2 it is (R+1)*32 cycles.
- R5: With src 3 the unit's external pin passes through two synchronising flops. Each rising edge decrements the count exactly once, however long the pin stays high.
- R6: With src 4, unit u counts once for every underflow of unit (u-1) mod N, one cycle after it. Both units keep their own interrupts.
- R7: A unit u≥1 with the link bit set counts in the same cycle that unit u-1 underflows, and it runs whenever unit u-1 runs. The combined period is the product of the (R+1) terms. The lower units of the chain raise no `irq_o`, `adc_trig_o` or `tog_o` activity. The link bit of unit 0 is ignored.
- R8: `tog_o` of a topmost unit inverts on every one of its underflows.
- R9: `adc_trig_o` pulses together with `irq_o` only when the unit's trigger-enable bit is set.
- R10: If a reload write lands on the same edge as an underflow, that underflow loads the old value. The new value takes effect from the following underflow.
- R11: Register map and field positions: `addr_i[0]`=0 writes the reload and reads the count; `addr_i[0]`=1 writes and reads the control register. `addr_i[ADDR_W-1:1]` selects the unit. The control fields are bits [2:0] for the source (0 clock, 1 div 8, 2 div 32, 3 external, 4 lower underflow, 5..7 never count), bit 3 for link, bit 4 for trigger enable and bit 5 for run. Reading control returns bits [5:0], and the upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | I/O clock |
| rst_n_i | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Unit index and register select |
| wdata_i | input | WIDTH | Write data |
| rdata_o | output | WIDTH | Count or control read-back (combinational) |
| ext_clk_i | input | N | Per-unit external count pins |
| irq_o | output | N | Per-unit underflow interrupt pulses |
| tog_o | output | N | Per-unit square-wave outputs |
| adc_trig_o | output | N | Per-unit A/D start pulses |

## Verification
A register write and an underflow can occur on the same edge. The sharpest case is a new reload value arriving exactly as the counter passes zero. The bench first locks onto an interrupt pulse to learn the counter's phase. It then times a reload write to land on the next underflow edge. It requires the pulse to still appear, the next gap to use the old reload, and the gap after that to use the new one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [2:0] {
      SRC_CLK   = 3'd0,
      SRC_DIV_A = 3'd1,
      SRC_DIV_B = 3'd2,
      SRC_EXT   = 3'd3,
      SRC_LOWER = 3'd4
   } tmr_src_e;

   typedef struct packed {
      logic     run;
      logic     trig_en;
      logic     link;
      tmr_src_e src;
   } tmr_ctl_t;

   localparam int CTL_W = $bits(tmr_ctl_t);
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int DIV_A = 8,
   parameter int DIV_B = 32
) (
   input  logic clk_i,
   input  logic rst_n_i,
   output logic tick_a_o,
   output logic tick_b_o
);
   localparam int PW = $clog2(DIV_B);
   localparam int AW = $clog2(DIV_A);

   if (DIV_A < 2 || (DIV_A & (DIV_A - 1)) != 0 || (DIV_B & (DIV_B - 1)) != 0 || DIV_B <= DIV_A)
   begin : g_bad_div
      $error("tmr_prescale: dividers must be powers of two with DIV_B > DIV_A >= 2");
   end

   logic [PW-1:0] pre_q;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) pre_q <= '0;
      else          pre_q <= pre_q + 1'b1;
   end

   assign tick_a_o = &pre_q[AW-1:0];
   assign tick_b_o = &pre_q;
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
   parameter int N = 4
) (
   input  logic         clk_i,
   input  logic         rst_n_i,
   input  logic [N-1:0] pin_i,
   output logic [N-1:0] rise_o
);
   logic [N-1:0] s1_q, s2_q, s3_q;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         s1_q <= '0;
         s2_q <= '0;
         s3_q <= '0;
      end else begin
         s1_q <= pin_i;
         s2_q <= s1_q;
         s3_q <= s2_q;
      end
   end

   assign rise_o = s2_q & ~s3_q;
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit #(
   parameter int WIDTH = 8
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             run_i,
   input  logic             step_i,
   input  logic [WIDTH-1:0] reload_i,
   output logic [WIDTH-1:0] cnt_o,
   output logic             uf_o
);
   logic [WIDTH-1:0] cnt_q;

   assign uf_o = run_i && step_i && (cnt_q == '0);

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)    cnt_q <= '0;
      else if (!run_i) cnt_q <= reload_i;
      else if (step_i) cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - 1'b1;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_cascade_group.sv
module tmr_cascade_group
   import tmr_pkg::*;
#(
   parameter int  N      = 4,
   parameter int  WIDTH  = 8,
   parameter int  DIV_A  = 8,
   parameter int  DIV_B  = 32,
   localparam int ADDR_W = $clog2(N) + 1
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [WIDTH-1:0]  wdata_i,
   output logic [WIDTH-1:0]  rdata_o,
   input  logic [N-1:0]      ext_clk_i,
   output logic [N-1:0]      irq_o,
   output logic [N-1:0]      tog_o,
   output logic [N-1:0]      adc_trig_o
);
   localparam int IDX_W = ADDR_W - 1;

   if (N < 2)          begin : g_bad_n     $error("tmr_cascade_group: N must be at least 2"); end
   if (WIDTH < CTL_W)  begin : g_bad_width $error("tmr_cascade_group: WIDTH too small for control"); end

   tmr_ctl_t         ctl_q    [N];
   logic [WIDTH-1:0] reload_q [N];
   logic [WIDTH-1:0] cnt      [N];
   logic [N-1:0]     link_eff, run_eff, step, uf, uf_q, top;
   logic [N-1:0]     irq_q, tog_q, trig_q;
   logic             tick_a, tick_b;
   logic [N-1:0]     ext_rise;
   logic [IDX_W-1:0] idx;
   logic             sel_ctl;

   assign idx     = addr_i[ADDR_W-1:1];
   assign sel_ctl = addr_i[0];

   tmr_prescale #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_pre (
      .clk_i(clk_i), .rst_n_i(rst_n_i), .tick_a_o(tick_a), .tick_b_o(tick_b));

   tmr_edge_sync #(.N(N)) u_sync (
      .clk_i(clk_i), .rst_n_i(rst_n_i), .pin_i(ext_clk_i), .rise_o(ext_rise));

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) uf_q <= '0;
      else          uf_q <= uf;
   end

   for (genvar u = 0; u < N; u++) begin : g_unit
      logic src_hit;

      always_ff @(posedge clk_i or negedge rst_n_i) begin
         if (!rst_n_i) begin
            ctl_q[u]    <= '0;
            reload_q[u] <= '0;
         end else if (wr_en_i && int'(idx) == u) begin
            if (sel_ctl) ctl_q[u]    <= tmr_ctl_t'(wdata_i[CTL_W-1:0]);
            else         reload_q[u] <= wdata_i;
         end
      end

      always_comb begin
         case (ctl_q[u].src)
            SRC_CLK:   src_hit = 1'b1;
            SRC_DIV_A: src_hit = tick_a;
            SRC_DIV_B: src_hit = tick_b;
            SRC_EXT:   src_hit = ext_rise[u];
            SRC_LOWER: src_hit = uf_q[(u + N - 1) % N];
            default:   src_hit = 1'b0;
         endcase
      end

      if (u == 0) begin : g_base
         assign link_eff[u] = 1'b0;
         assign run_eff[u]  = ctl_q[u].run;
         assign step[u]     = src_hit;
      end else begin : g_linkable
         assign link_eff[u] = ctl_q[u].link;
         assign run_eff[u]  = link_eff[u] ? run_eff[u-1] : ctl_q[u].run;
         assign step[u]     = link_eff[u] ? uf[u-1] : src_hit;
      end

      if (u == N - 1) begin : g_last
         assign top[u] = 1'b1;
      end else begin : g_inner
         assign top[u] = ~link_eff[u+1];
      end

      tmr_unit #(.WIDTH(WIDTH)) u_cnt (
         .clk_i   (clk_i),
         .rst_n_i (rst_n_i),
         .run_i   (run_eff[u]),
         .step_i  (step[u]),
         .reload_i(reload_q[u]),
         .cnt_o   (cnt[u]),
         .uf_o    (uf[u]));

      always_ff @(posedge clk_i or negedge rst_n_i) begin
         if (!rst_n_i) begin
            irq_q[u]  <= 1'b0;
            trig_q[u] <= 1'b0;
            tog_q[u]  <= 1'b0;
         end else begin
            irq_q[u]  <= uf[u] & top[u];
            trig_q[u] <= uf[u] & top[u] & ctl_q[u].trig_en;
            if (!run_eff[u])          tog_q[u] <= 1'b0;
            else if (uf[u] & top[u])  tog_q[u] <= ~tog_q[u];
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      for (int u = 0; u < N; u++) begin
         if (int'(idx) == u) begin
            if (sel_ctl) rdata_o[CTL_W-1:0] = ctl_q[u];
            else         rdata_o            = cnt[u];
         end
      end
   end

   assign irq_o      = irq_q;
   assign tog_o      = tog_q;
   assign adc_trig_o = trig_q;
endmodule

// File: rtl/tmr_cascade_chk.sv
module tmr_cascade_chk #(
   parameter int N = 4
) (
   input logic         clk_i,
   input logic         rst_n_i,
   input logic [N-1:0] run_eff,
   input logic [N-1:0] link_eff,
   input logic [N-1:0] irq,
   input logic [N-1:0] tog,
   input logic [N-1:0] trig
);
   for (genvar u = 0; u < N; u++) begin : g_chk
      AST_STOPPED_TOG_LOW: assert property (@(posedge clk_i) disable iff (!rst_n_i)
         !$past(run_eff[u]) |-> !tog[u]); // R2
      AST_STOPPED_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_n_i)
         !$past(run_eff[u]) |-> !irq[u]); // R2
      AST_TOG_ON_IRQ: assert property (@(posedge clk_i) disable iff (!rst_n_i)
         irq[u] |-> (tog[u] != $past(tog[u]))); // R8
      AST_TRIG_WITH_IRQ: assert property (@(posedge clk_i) disable iff (!rst_n_i)
         trig[u] |-> irq[u]); // R9
      if (u < N - 1) begin : g_lower
         AST_LOWER_SILENT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            $past(link_eff[u+1]) |-> !irq[u]); // R7
      end
   end
endmodule

bind tmr_cascade_group tmr_cascade_chk #(.N(N)) u_chk (
   .clk_i   (clk_i),
   .rst_n_i (rst_n_i),
   .run_eff (run_eff),
   .link_eff(link_eff),
   .irq     (irq_o),
   .tog     (tog_o),
   .trig    (adc_trig_o));

// File: tb/tb_tmr_cascade_group.sv
module tb_tmr_cascade_group;
   localparam int CLK_P = 10;
   localparam int N = 4;
   localparam int WIDTH = 8;
   localparam int ADDR_W = $clog2(N) + 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [WIDTH-1:0]  wdata = '0;
   logic [WIDTH-1:0]  rdata;
   logic [N-1:0]      ext = '0;
   logic [N-1:0]      irq, tog, trig;

   int n_chk = 0;
   int n_bad = 0;
   int irq_cnt [N];
   int trig_cnt [N];

   tmr_cascade_group #(.N(N), .WIDTH(WIDTH)) dut (
      .clk_i(clk), .rst_n_i(rst_n), .wr_en_i(wr_en), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .ext_clk_i(ext),
      .irq_o(irq), .tog_o(tog), .adc_trig_o(trig));

   always #(CLK_P/2) clk = ~clk;

   initial for (int u = 0; u < N; u++) begin irq_cnt[u] = 0; trig_cnt[u] = 0; end

   always @(negedge clk) begin
      for (int u = 0; u < N; u++) begin
         if (irq[u])  irq_cnt[u]  = irq_cnt[u] + 1;
         if (trig[u]) trig_cnt[u] = trig_cnt[u] + 1;
      end
   end

   function automatic logic [WIDTH-1:0] ctlv(int src, bit link, bit trg, bit run);
      return WIDTH'((int'(run) << 5) | (int'(trg) << 4) | (int'(link) << 3) | src);
   endfunction

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(int u, bit ctl, logic [WIDTH-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = ADDR_W'(u * 2 + int'(ctl)); wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(int u, bit ctl, output int v);
      @(negedge clk);
      addr = ADDR_W'(u * 2 + int'(ctl));
      #1 v = int'(rdata);
   endtask

   task automatic wait_irq(int u, output int n);
      n = 0;
      do begin @(negedge clk); n++; end while (!irq[u] && n < 3000);
   endtask

   task automatic stop_all();
      for (int u = 0; u < N; u++) begin wr(u, 1, '0); wr(u, 0, '0); end
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      int v;
      for (int u = 0; u < N; u++) begin
         rd(u, 0, v); check("R1 count", v, 0);
      end
      check("R1 irq", int'(irq), 0);
      check("R1 tog", int'(tog), 0);
      check("R1 trig", int'(trig), 0);
   endtask

   task automatic t_stopped();
      int v;
      wr(0, 0, 8'h5A);
      rd(0, 0, v); check("R2 count follows reload", v, 'h5A);
      check("R2 tog low", int'(tog[0]), 0);
      stop_all();
   endtask

   task automatic t_map();
      int v;
      wr(2, 1, 8'hC7);
      rd(2, 1, v); check("R11 control readback", v, 'h07);
      wr(2, 1, 8'h00);
   endtask

   task automatic t_clk();
      int n, v, t0, base;
      wr(0, 0, 8'd4);
      wr(0, 1, ctlv(0, 0, 0, 1));
      wait_irq(0, n); check("R3 first latency", n, 5);
      t0 = int'(tog[0]);
      check("R8 tog set on first", t0, 1);
      @(negedge clk); check("R3 one-cycle pulse", int'(irq[0]), 0);
      wait_irq(0, n); check("R3 period", n + 1, 5);
      check("R8 tog inverts", int'(tog[0]), 1 - t0);
      wr(0, 1, ctlv(0, 0, 0, 0));
      check("R2 tog cleared on stop", int'(tog[0]), 0);
      base = irq_cnt[0];
      repeat (20) @(negedge clk);
      check("R2 no irq while stopped", irq_cnt[0] - base, 0);
      rd(0, 0, v); check("R2 count back to reload", v, 4);
      stop_all();
   endtask

   task automatic t_prescale();
      int n;
      wr(0, 0, 8'd1);
      wr(0, 1, ctlv(1, 0, 0, 1));
      wait_irq(0, n);
      wait_irq(0, n); check("R4 div8 period", n, 16);
      wait_irq(0, n); check("R4 div8 period again", n, 16);
      stop_all();
      wr(1, 0, 8'd0);
      wr(1, 1, ctlv(2, 0, 0, 1));
      wait_irq(1, n);
      wait_irq(1, n); check("R4 div32 period", n, 32);
      stop_all();
   endtask

   task automatic ext_pulse(int u);
      @(negedge clk); ext[u] = 1'b1;
      repeat (3) @(negedge clk);
      ext[u] = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_ext();
      int v, base;
      wr(2, 0, 8'd2);
      wr(2, 1, ctlv(3, 0, 0, 1));
      base = irq_cnt[2];
      ext_pulse(2);
      rd(2, 0, v); check("R5 one step per edge", v, 1);
      ext_pulse(2);
      check("R5 no irq after two edges", irq_cnt[2] - base, 0);
      ext_pulse(2);
      check("R5 irq after three edges", irq_cnt[2] - base, 1);
      stop_all();
   endtask

   task automatic t_lower();
      int n, base0;
      wr(0, 0, 8'd1);
      wr(1, 0, 8'd1);
      wr(1, 1, ctlv(4, 0, 0, 1));
      wr(0, 1, ctlv(0, 0, 0, 1));
      wait_irq(1, n);
      base0 = irq_cnt[0];
      wait_irq(1, n); check("R6 lower-underflow period", n, 4);
      check("R6 lower keeps irq", irq_cnt[0] - base0, 2);
      stop_all();
   endtask

   task automatic t_link16();
      int n, base0;
      wr(0, 0, 8'd3);
      wr(1, 0, 8'd2);
      wr(1, 1, ctlv(0, 1, 0, 0));
      wr(0, 1, ctlv(0, 0, 1, 1));
      wait_irq(1, n);
      base0 = irq_cnt[0];
      wait_irq(1, n); check("R7 16-bit period", n, 12);
      check("R7 lower irq silent", irq_cnt[0] - base0, 0);
      check("R7 lower tog silent", int'(tog[0]), 0);
      check("R7 lower trig silent", trig_cnt[0], 0);
      stop_all();
   endtask

   task automatic t_link32();
      int n, b0, b1, b2, bt;
      for (int u = 0; u < N; u++) wr(u, 0, 8'd1);
      wr(3, 1, ctlv(0, 1, 1, 0));
      wr(2, 1, ctlv(0, 1, 0, 0));
      wr(1, 1, ctlv(0, 1, 0, 0));
      wr(0, 1, ctlv(0, 0, 0, 1));
      wait_irq(3, n);
      b0 = irq_cnt[0]; b1 = irq_cnt[1]; b2 = irq_cnt[2]; bt = trig_cnt[3];
      check("R9 trig with irq", int'(trig[3]), 1);
      wait_irq(3, n); check("R7 32-bit period", n, 16);
      check("R7 inner irqs silent", (irq_cnt[0] - b0) + (irq_cnt[1] - b1) + (irq_cnt[2] - b2), 0);
      check("R9 trig count", trig_cnt[3] - bt, 1);
      stop_all();
      wr(3, 0, 8'd0);
      wr(3, 1, ctlv(0, 0, 0, 1));
      bt = trig_cnt[3];
      repeat (10) @(negedge clk);
      check("R9 no trig when disabled", trig_cnt[3] - bt, 0);
      stop_all();
   endtask

   task automatic t_race();
      int n;
      wr(0, 0, 8'd5);
      wr(0, 1, ctlv(0, 0, 0, 1));
      wait_irq(0, n);
      repeat (4) @(negedge clk);
      wr(0, 0, 8'd2);
      check("R10 underflow on write edge", int'(irq[0]), 1);
      wait_irq(0, n); check("R10 old reload used", n, 6);
      wait_irq(0, n); check("R10 new reload used", n, 3);
      stop_all();
   endtask

   initial begin
      #(CLK_P * 200000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_stopped();
      t_map();
      t_clk();
      t_prescale();
      t_ext();
      t_lower();
      t_link16();
      t_link32();
      t_race();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule